// File: doc/BRIEF.md
# SD Card Interface Power and Clock Controller

This block owns the electrical state of an SD/MMC card interface and produces the card clock. Software writes two control words through a simple register port: a power word that picks one of three line-drive states, and a clock word that sets a divider, the launch edge, the bus width and a power-save option. The block forces the CK, CMD and data lines low while the card is being power cycled, forces them high while the interface is off, and releases them only in the active state.

In the active state the card clock is the system clock divided by twice the divider value, or the raw system clock when the divider is zero. A launch strobe marks the system cycle on whose edge command and data outputs should change. After the active state is entered, an enable flag stays low until 74 card clock rising edges have been produced, which is the initialisation time a card needs before it accepts commands. An optional power-save mode freezes the card clock whenever the bus reports idle.

Top module: `sd_pwrclk_ctrl`

## Requirements
- R1: After synchronous reset the power state reads 00 (off), the divider, edge, power-save and width fields read 0, `if_enable` is 0, and the lines are forced high with `card_clk` high.
- R2: In power state 00 (off) `line_force`=1, `line_level`=1, `card_clk`=1 and `if_enable`=0.
- R3: In power state 10 (cycle) `line_force`=1, `line_level`=0 and `card_clk`=0.
- R4: A power word whose state field (bits 1:0) is 01 is ignored entirely: state and polarity keep their previous values.
- R5: In power state 11 (on) `line_force`=0; `if_enable` goes high together with the 74th card clock rising edge after entry and not before; leaving the on state restarts that count.
- R6: With divider N (clock word bits 9:0) nonzero, `card_clk` has a period of 2·N system cycles and is high for N of them; N=1023 gives 2046.
- R7: With divider 0 the card clock is the system clock itself, `launch` is high in every running cycle (outputs change on its falling edge), and `if_enable` rises 74 system cycles after the write that entered the on state.
- R8: With N>0, clock word bit 10 clear makes `launch` precede a rising edge of `card_clk`; bit 10 set makes it precede a falling edge.
- R9: `bus_width` is 0 for 1-bit, 1 when clock word bit 12 alone is set (4-bit), 2 when bit 13 is set (8-bit, taking precedence over bit 12).
- R10: With clock word bit 11 set and `bus_idle` high, `card_clk` makes no edge; it resumes once `bus_idle` falls.
- R11: Reading address 0 returns state in bits 1:0 and polarity in bit 4; address 1 returns divider 9:0, edge 10, power-save 11, width bits 13:12; other bits read 0.
- R12: `dir_pol` follows power word bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = power word, 1 = clock word |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read select, same decoding as `wr_addr` |
| rd_data | output | 16 | Read data |
| bus_idle | input | 1 | High while no command or data transfer is in progress |
| card_clk | output | 1 | Card clock |
| launch | output | 1 | Marks the cycle whose edge updates command and data outputs |
| if_enable | output | 1 | Interface ready for commands |
| line_force | output | 1 | Lines CK, CMD and D are forced by this block |
| line_level | output | 1 | Level of the forced lines |
| bus_width | output | 2 | Data bus width code |
| dir_pol | output | 1 | Signal direction polarity |
| pwr_state | output | 2 | Current power state |

## Verification
The bench counts card clock edges up to the enable point in both divided and bypass modes and checks the flag at edge 73 and 74, catching an off-by-one or a counter that ignores the clock rate. It measures period and high time for random dividers and for the saturated value 1023, which a divider counting to N instead of N-1 would get wrong by two cycles. It writes the reserved state code and reads it back, re-enters power-on after a cycle state to prove the wake count restarts, and holds the bus idle with power save on to show a clock that keeps toggling or never resumes.

// File: rtl/sd_pwrclk_ctrl.sv
module sd_pwrclk_ctrl #(
  parameter int DIV_W     = 10,
  parameter int WAKE_CLKS = 74,
  parameter int REG_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             bus_idle,
  output logic             card_clk,
  output logic             launch,
  output logic             if_enable,
  output logic             line_force,
  output logic             line_level,
  output logic [1:0]       bus_width,
  output logic             dir_pol,
  output logic [1:0]       pwr_state
);
  localparam int WK_W = $clog2(WAKE_CLKS + 1);
  localparam logic [1:0] ST_OFF = 2'b00;
  localparam logic [1:0] ST_CYC = 2'b10;
  localparam logic [1:0] ST_ON  = 2'b11;
  localparam int B_EDGE = DIV_W;
  localparam int B_SAVE = DIV_W + 1;
  localparam int B_W4   = DIV_W + 2;
  localparam int B_W8   = DIV_W + 3;
  localparam int B_POL  = 4;

  logic [1:0]       state_q;
  logic             pol_q;
  logic [DIV_W-1:0] div_q;
  logic             edge_q, save_q, w4_q, w8_q;
  logic [DIV_W-1:0] cnt_q;
  logic             ck_q;
  logic [WK_W-1:0]  wake_q;
  logic             run_q;

  logic is_on, bypass, run, tick, rise, clk_wr;

  assign is_on  = (state_q == ST_ON);
  assign bypass = (div_q == '0);
  assign run    = is_on & ~(save_q & bus_idle);
  assign tick   = run & ~bypass & (cnt_q == div_q - 1'b1);
  assign rise   = bypass ? run : (tick & ~ck_q);
  assign clk_wr = wr_en & wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      pol_q   <= 1'b0;
      div_q   <= '0;
      edge_q  <= 1'b0;
      save_q  <= 1'b0;
      w4_q    <= 1'b0;
      w8_q    <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        if (wr_data[1:0] != 2'b01) begin
          state_q <= wr_data[1:0];
          pol_q   <= wr_data[B_POL];
        end
      end else begin
        div_q  <= wr_data[DIV_W-1:0];
        edge_q <= wr_data[B_EDGE];
        save_q <= wr_data[B_SAVE];
        w4_q   <= wr_data[B_W4];
        w8_q   <= wr_data[B_W8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !is_on) begin
      cnt_q <= '0;
      ck_q  <= 1'b0;
    end else if (clk_wr) begin
      cnt_q <= '0;
    end else if (run && !bypass) begin
      if (tick) begin
        cnt_q <= '0;
        ck_q  <= ~ck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !is_on)
      wake_q <= '0;
    else if (rise && wake_q != WK_W'(WAKE_CLKS))
      wake_q <= wake_q + 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run & bypass;
  end

  always_comb begin
    case (state_q)
      ST_ON:   card_clk = bypass ? (clk & run_q) : ck_q;
      ST_CYC:  card_clk = 1'b0;
      default: card_clk = 1'b1;
    endcase
  end

  assign launch     = run & (bypass | (tick & (ck_q == edge_q)));
  assign if_enable  = is_on & (wake_q == WK_W'(WAKE_CLKS));
  assign line_force = ~is_on;
  assign line_level = (state_q == ST_OFF);
  assign bus_width  = w8_q ? 2'd2 : (w4_q ? 2'd1 : 2'd0);
  assign dir_pol    = pol_q;
  assign pwr_state  = state_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data[DIV_W-1:0] = div_q;
      rd_data[B_EDGE]    = edge_q;
      rd_data[B_SAVE]    = save_q;
      rd_data[B_W4]      = w4_q;
      rd_data[B_W8]      = w8_q;
    end else begin
      rd_data[1:0]  = state_q;
      rd_data[B_POL] = pol_q;
    end
  end
endmodule

// File: rtl/sd_pwrclk_ctrl_chk.sv
module sd_pwrclk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       card_clk,
  input logic       if_enable,
  input logic       line_force,
  input logic       line_level,
  input logic [1:0] bus_width,
  input logic [1:0] pwr_state
);
  assert_off_high_R2: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'b00 |-> line_force && line_level && card_clk && !if_enable);

  assert_cycle_low_R3: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'b10 |-> line_force && !line_level && !card_clk);

  assert_no_reserved_R4: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'b01);

  assert_released_R5: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'b11 |-> !line_force);

  assert_enable_only_on_R5: assert property (@(posedge clk) disable iff (rst)
    if_enable |-> pwr_state == 2'b11);

  assert_enable_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(if_enable) |-> $past(pwr_state) == 2'b11);

  assert_width_code_R9: assert property (@(posedge clk) disable iff (rst)
    bus_width != 2'b11);
endmodule

bind sd_pwrclk_ctrl sd_pwrclk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .card_clk(card_clk), .if_enable(if_enable),
  .line_force(line_force), .line_level(line_level),
  .bus_width(bus_width), .pwr_state(pwr_state)
);

// File: tb/sd_pwrclk_ctrl_tb.sv
module sd_pwrclk_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [15:0] rd_data;
  logic        bus_idle = 1'b0;
  logic        card_clk, launch, if_enable, line_force, line_level, dir_pol;
  logic [1:0]  bus_width, pwr_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sd_pwrclk_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_idle(bus_idle),
    .card_clk(card_clk), .launch(launch), .if_enable(if_enable),
    .line_force(line_force), .line_level(line_level), .bus_width(bus_width),
    .dir_pol(dir_pol), .pwr_state(pwr_state)
  );

  function automatic int exp_width(bit w4, bit w8);
    return w8 ? 2 : (w4 ? 1 : 0);
  endfunction

  function automatic logic [15:0] clk_word(int n, bit edg, bit save, bit w4, bit w8);
    logic [15:0] w = '0;
    w[9:0] = 10'(n); w[10] = edg; w[11] = save; w[12] = w4; w[13] = w8;
    return w;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(bit a, output logic [15:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic wait_rise();
    logic p;
    p = card_clk;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!p && card_clk) return;
      p = card_clk;
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic p;
    wait_rise();
    per = 0; hi = 0; p = card_clk;
    for (int i = 0; i < 5000; i++) begin
      if (card_clk) hi++;
      @(negedge clk);
      per++;
      if (!p && card_clk) return;
      p = card_clk;
    end
  endtask

  task automatic wake_divided(int n);
    int rises; logic p;
    wr(0, 16'h0000);
    wr(1, clk_word(n, 0, 0, 0, 0));
    wr(0, 16'h0003);
    rises = 0; p = card_clk;
    while (rises < 74) begin
      @(negedge clk);
      if (!p && card_clk) begin
        rises++;
        if (rises == 73) check("R5 enable at rise 73", if_enable, 0);
        if (rises == 74) check("R5 enable at rise 74", if_enable, 1);
      end
      p = card_clk;
    end
  endtask

  initial begin
    logic [15:0] d;
    int per, hi, n;
    bit e, w4, w8;
    void'($urandom(32'h5d1c));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(0, d); check("R1 state after reset", d, 0);
    rd(1, d); check("R1 clock word after reset", d, 0);
    check("R1 enable after reset", if_enable, 0);
    check("R1 card clk high", card_clk, 1);
    check("R2 off forces lines", line_force, 1);
    check("R2 off level high", line_level, 1);

    wr(0, 16'h0012);
    check("R3 cycle force", line_force, 1);
    check("R3 cycle level low", line_level, 0);
    check("R3 cycle clk low", card_clk, 0);
    check("R12 polarity", dir_pol, 1);
    wr(0, 16'h0001);
    rd(0, d); check("R4 reserved code ignored", d, 16'h0012);
    check("R4 polarity kept", dir_pol, 1);
    wr(0, 16'h0000);
    check("R2 off level", line_level, 1);
    check("R12 polarity clear", dir_pol, 0);

    wr(1, clk_word(5, 1, 0, 1, 0));
    rd(1, d); check("R11 clock word readback", d, 16'h1405);
    wr(0, 16'h0013);
    rd(0, d); check("R11 power word readback", d, 16'h0013);
    check("R5 lines released", line_force, 0);

    wake_divided(2);
    wr(0, 16'h0002);
    wr(0, 16'h0003);
    check("R5 restart after cycle", if_enable, 0);
    wake_divided(3);

    wr(1, clk_word(0, 0, 0, 0, 0));
    wr(0, 16'h0000);
    wr(0, 16'h0003);
    for (int k = 1; k <= 74; k++) begin
      @(negedge clk);
      if (k == 1) check("R7 bypass launch", launch, 1);
      if (k == 73) check("R7 bypass enable at 73", if_enable, 0);
      if (k == 74) check("R7 bypass enable at 74", if_enable, 1);
    end
    @(posedge clk); #1;
    check("R7 bypass clk follows system clock high", card_clk, 1);
    @(negedge clk); #1;
    check("R7 bypass clk follows system clock low", card_clk, 0);

    for (int t = 0; t < 6; t++) begin
      n = 1 + ($urandom % 12);
      wr(1, clk_word(n, 0, 0, 0, 0));
      wait_rise();
      measure(per, hi);
      check("R6 period", per, 2 * n);
      check("R6 high time", hi, n);
    end
    wr(1, clk_word(1023, 0, 0, 0, 0));
    wait_rise();
    measure(per, hi);
    check("R6 period at divider 1023", per, 2046);

    for (int m = 0; m < 2; m++) begin
      int seen, good; logic want;
      wr(1, clk_word(3, m[0], 0, 0, 0));
      wait_rise();
      seen = 0; good = 0; want = m[0] ? 1'b0 : 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (launch) begin
          logic b;
          b = card_clk;
          @(negedge clk);
          seen++;
          if (b != want && card_clk == want) good++;
        end
      end
      check(m[0] ? "R8 launch before falling edge" : "R8 launch before rising edge", good, seen);
      check("R8 launch occurs", seen > 0, 1);
    end

    for (int t = 0; t < 6; t++) begin
      w4 = $urandom % 2; w8 = $urandom % 2; e = $urandom % 2;
      wr(1, clk_word(2, e, 0, w4, w8));
      check("R9 width code", bus_width, exp_width(w4, w8));
    end

    begin
      int edges; logic p;
      wr(1, clk_word(2, 0, 1, 0, 0));
      bus_idle = 1'b1;
      @(negedge clk);
      edges = 0; p = card_clk;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (card_clk != p) edges++;
        p = card_clk;
      end
      check("R10 idle clock frozen", edges, 0);
      bus_idle = 1'b0;
      edges = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (card_clk != p) edges++;
        p = card_clk;
      end
      check("R10 clock resumes", edges > 0, 1);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule